// File: doc/BRIEF.md
# Scanline interrupt down-counter

This block raises an interrupt after a programmed number of rendered scanlines. A video address line toggles a few times within each scanline while rendering is on. A filter turns it into one counter tick per line by accepting a rising edge only after the line has sat low for long enough. Each tick either decrements an 8-bit down-counter or, when the counter already reads zero, reloads it from a latch. When the count lands on zero after a tick and the interrupt is enabled, a pending flag is set. The active-low request output follows that flag.

Software reaches the block through a byte-wide write port. Only the address bits under the mask 0xE001 are decoded, so each of the four registers also answers at its mirrored addresses. Reloading is a request: a write clears the count, and the actual load from the latch happens on the next tick. A latch value of zero therefore produces an interrupt on every scanline.

Top module: `line_irq_counter`

## Requirements
- R1: After reset the counter, the latch, the enable bit and the pending flag are all zero, and `irqN` is high.
- R2: A write is decoded on `wrAddr & 16'hE001`. Mirrored addresses (for example 0xD000 acts as 0xC000, and 0xDFFF acts as 0xC001) behave like their base address. Writes whose masked address is 0x8000, 0x8001, 0xA000 or 0xA001 change nothing.
- R3: A write to masked address 0xC000 stores `wrData` in the reload latch and leaves the counter unchanged.
- R4: A write to masked address 0xC001 clears the counter to zero, so the next tick loads it from the latch.
- R5: On a tick the counter loads the latch when it reads zero and otherwise decrements by one. Without a tick or a reload write it holds its value.
- R6: When the counter is zero after a tick and the enable bit is set, the pending flag is set. `irqN` is low exactly while the pending flag is set.
- R7: A write to masked address 0xE000 clears both the enable bit and the pending flag.
- R8: A write to masked address 0xE001 sets the enable bit and leaves the pending flag as it was.
- R9: A rising edge on `a12In` makes a tick only when `a12In` was sampled low on at least 3 consecutive clocks before it. Shorter low pulses produce no tick.
- R10: With a latch of zero, every tick leaves the counter at zero, so an enabled interrupt is raised on every scanline.
- R11: A zero count reached while the interrupt is disabled sets nothing. Enabling the interrupt afterwards does not raise the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrAddr | input | 16 | Write address, decoded under mask 0xE001 |
| wrData | input | 8 | Write data |
| a12In | input | 1 | Video address line used as the scanline clock |
| irqN | output | 1 | Active-low interrupt request |

## Verification
The pending flag drives `irqN` directly, so a wrong enable bit or a wrong pending flag shows at the pin in the cycle after the offending write or tick. A wrong count or latch value stays hidden until the counter next reaches zero. Up to a full reload period of scanlines can pass before the request arrives early, late or not at all. The bench therefore runs counts through complete periods, including a reload request made part-way through a period, so that a stale count shifts the point where the interrupt fires. A filter that lets glitches through, or that rejects real edges, likewise shows up only as a shifted interrupt scanline.

// File: rtl/line_irq_pkg.sv
package line_irq_pkg;

  // One-cycle command strobes from the write decoder to the datapath
  typedef struct packed {
    logic latchWr;    // store write data into the reload latch
    logic reloadReq;  // clear the count so the next tick reloads it
    logic irqOff;     // drop enable and acknowledge pending
    logic irqOn;      // raise enable
  } irq_strb_t;

endpackage

// File: rtl/line_irq_a12_filter.sv
module line_irq_a12_filter #(
  parameter int LOW_MIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a12In,
  output logic lineTick
);
  localparam int LCW = $clog2(LOW_MIN + 1);

  logic           a12Q;
  logic [LCW-1:0] lowRun;
  logic           armed;

  assign armed = (lowRun >= LCW'(LOW_MIN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a12Q     <= 1'b1;
      lowRun   <= '0;
      lineTick <= 1'b0;
    end else begin
      a12Q     <= a12In;
      lineTick <= a12Q && armed;
      if (a12Q)        lowRun <= '0;
      else if (!armed) lowRun <= lowRun + LCW'(1);
    end
  end

  // R9: a qualified edge gives exactly one tick
  p_single_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lineTick |=> !lineTick);

endmodule

// File: rtl/line_irq_ctrl.sv
module line_irq_ctrl
  import line_irq_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] DEC_MASK   = 16'hE001,
  parameter logic [15:0] ADR_LATCH  = 16'hC000,
  parameter logic [15:0] ADR_RELOAD = 16'hC001,
  parameter logic [15:0] ADR_OFF    = 16'hE000,
  parameter logic [15:0] ADR_ON     = 16'hE001
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output irq_strb_t         strb
);
  logic [ADDR_W-1:0] masked;

  assign masked = wrAddr & ADDR_W'(DEC_MASK);

  always_comb begin
    strb = '0;
    if (wrEn) begin
      if (masked == ADDR_W'(ADR_LATCH))  strb.latchWr   = 1'b1;
      if (masked == ADDR_W'(ADR_RELOAD)) strb.reloadReq = 1'b1;
      if (masked == ADDR_W'(ADR_OFF))    strb.irqOff    = 1'b1;
      if (masked == ADDR_W'(ADR_ON))     strb.irqOn     = 1'b1;
    end
  end

endmodule

// File: rtl/line_irq_dp.sv
module line_irq_dp
  import line_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  irq_strb_t        strb,
  input  logic [CNT_W-1:0] wrData,
  input  logic             lineTick,
  output logic             pendQ
);
  logic [CNT_W-1:0] latchQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] nextCnt;
  logic             enQ;

  assign nextCnt = (cntQ == '0) ? latchQ : cntQ - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latchQ <= '0;
      cntQ   <= '0;
      enQ    <= 1'b0;
      pendQ  <= 1'b0;
    end else begin
      if (strb.latchWr) latchQ <= wrData;

      if (strb.reloadReq)  cntQ <= '0;
      else if (lineTick)   cntQ <= nextCnt;

      if (strb.irqOff)     enQ <= 1'b0;
      else if (strb.irqOn) enQ <= 1'b1;

      if (strb.irqOff)
        pendQ <= 1'b0;
      else if (lineTick && !strb.reloadReq && nextCnt == '0 && enQ)
        pendQ <= 1'b1;
    end
  end

  // R6: pending rises only from a tick while enabled
  p_rise_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pendQ) |-> $past(enQ) && $past(lineTick));
  // R7: acknowledge drops enable and pending
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.irqOff |=> !pendQ && !enQ);
  // R4: reload request leaves the count at zero
  p_reload_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.reloadReq |=> cntQ == '0);
  // R5: no tick, no reload -> count holds
  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lineTick && !strb.reloadReq |=> $stable(cntQ));
  // R8: enabling does not touch pending
  p_on_keeps_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.irqOn && !lineTick |=> pendQ == $past(pendQ));
  // R3: latch takes the written byte
  p_latch_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.latchWr |=> latchQ == $past(wrData));

endmodule

// File: rtl/line_irq_counter.sv
module line_irq_counter
  import line_irq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int LOW_MIN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              a12In,
  output logic              irqN
);
  localparam int CNT_W = DATA_W;

  irq_strb_t strb;
  logic      lineTick;
  logic      pendQ;

  line_irq_a12_filter #(.LOW_MIN(LOW_MIN)) u_filter (
    .clk(clk), .rst_n(rst_n), .a12In(a12In), .lineTick(lineTick)
  );

  line_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .strb(strb)
  );

  line_irq_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrData(wrData),
    .lineTick(lineTick), .pendQ(pendQ)
  );

  assign irqN = ~pendQ;

endmodule

// File: tb/line_irq_counter_bench.sv
`timescale 1ns/1ps
module line_irq_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        a12In = 1'b1;
  logic        irqN;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  line_irq_counter u_line_irq_counter (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .a12In(a12In), .irqN(irqN)
  );

  // op: 0 = write, 1 = scanline (4 low samples), 2 = glitch (2 low samples)
  localparam int NV = 50;
  localparam logic [26:0] VECS [0:NV-1] = '{
    {2'd0,16'hC000,8'h03,1'b1}, // 0  R3 latch 3
    {2'd0,16'hC001,8'h00,1'b1}, // 1  R4 reload
    {2'd0,16'hE001,8'h00,1'b1}, // 2  R8 enable
    {2'd1,16'h0000,8'h00,1'b1}, // 3  R5 load 3
    {2'd1,16'h0000,8'h00,1'b1}, // 4  R5 2
    {2'd2,16'h0000,8'h00,1'b1}, // 5  R9 glitch ignored
    {2'd1,16'h0000,8'h00,1'b1}, // 6  R5 1
    {2'd1,16'h0000,8'h00,1'b0}, // 7  R6 zero -> irq
    {2'd0,16'hE001,8'h00,1'b0}, // 8  R8 pending kept
    {2'd0,16'hE000,8'h00,1'b1}, // 9  R7 ack
    {2'd1,16'h0000,8'h00,1'b1}, // 10 R5 load 3
    {2'd0,16'hE001,8'h00,1'b1}, // 11 R8
    {2'd1,16'h0000,8'h00,1'b1}, // 12 2
    {2'd1,16'h0000,8'h00,1'b1}, // 13 1
    {2'd1,16'h0000,8'h00,1'b0}, // 14 R6
    {2'd0,16'hE000,8'h00,1'b1}, // 15 R7
    {2'd0,16'hE001,8'h00,1'b1}, // 16
    {2'd0,16'hC000,8'h00,1'b1}, // 17 R10 latch 0
    {2'd1,16'h0000,8'h00,1'b0}, // 18 R10 every line
    {2'd0,16'hE000,8'h00,1'b1}, // 19
    {2'd0,16'hE001,8'h00,1'b1}, // 20
    {2'd1,16'h0000,8'h00,1'b0}, // 21 R10 again
    {2'd0,16'hE000,8'h00,1'b1}, // 22
    {2'd0,16'hE001,8'h00,1'b1}, // 23
    {2'd0,16'hD000,8'h05,1'b1}, // 24 R2 mirror latch 5
    {2'd0,16'hDFFF,8'h00,1'b1}, // 25 R2 mirror reload
    {2'd1,16'h0000,8'h00,1'b1}, // 26 load 5
    {2'd0,16'h8001,8'h00,1'b1}, // 27 R2 ignored
    {2'd0,16'hA000,8'h00,1'b1}, // 28 R2 ignored
    {2'd1,16'h0000,8'h00,1'b1}, // 29 4
    {2'd1,16'h0000,8'h00,1'b1}, // 30 3
    {2'd1,16'h0000,8'h00,1'b1}, // 31 2
    {2'd1,16'h0000,8'h00,1'b1}, // 32 1
    {2'd1,16'h0000,8'h00,1'b0}, // 33 R2 count intact -> irq
    {2'd0,16'hE000,8'h00,1'b1}, // 34 R11 disable
    {2'd1,16'h0000,8'h00,1'b1}, // 35 load 5
    {2'd1,16'h0000,8'h00,1'b1}, // 36 4
    {2'd1,16'h0000,8'h00,1'b1}, // 37 3
    {2'd1,16'h0000,8'h00,1'b1}, // 38 2
    {2'd1,16'h0000,8'h00,1'b1}, // 39 1
    {2'd1,16'h0000,8'h00,1'b1}, // 40 R11 zero while disabled
    {2'd0,16'hE001,8'h00,1'b1}, // 41 R11 no late irq
    {2'd1,16'h0000,8'h00,1'b1}, // 42 load 5
    {2'd0,16'hC001,8'h00,1'b1}, // 43 R4 reload mid-period
    {2'd1,16'h0000,8'h00,1'b1}, // 44 R4 load 5 (not 4)
    {2'd1,16'h0000,8'h00,1'b1}, // 45 4
    {2'd1,16'h0000,8'h00,1'b1}, // 46 3
    {2'd1,16'h0000,8'h00,1'b1}, // 47 2
    {2'd1,16'h0000,8'h00,1'b1}, // 48 1
    {2'd1,16'h0000,8'h00,1'b0}  // 49 R4 R5 irq after full period
  };

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doLine(input int lowCycles);
    @(negedge clk);
    a12In = 1'b0;
    repeat (lowCycles) @(negedge clk);
    a12In = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: irqN=%b expected %b", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", irqN, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", irqN, 1'b1);

    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VECS[i];
      case (v[26:25])
        2'd0: doWrite(v[24:9], v[8:1]);
        2'd1: doLine(4);
        default: doLine(2);
      endcase
      check($sformatf("R2-table step %0d", i), irqN, v[0]);
    end

    // R9: low for exactly 3 samples is a valid tick; latch 1 set up first
    doWrite(16'hE000, 8'h00);
    doWrite(16'hC000, 8'h01);
    doWrite(16'hC001, 8'h00);
    doWrite(16'hE001, 8'h00);
    doLine(3);             // load 1
    check("R9 first tick", irqN, 1'b1);
    doLine(2);             // rejected
    check("R9 two-sample glitch", irqN, 1'b1);
    doLine(3);             // 1 -> 0
    check("R9 three-sample edge", irqN, 1'b0);

    // R1: reset mid-run clears latch and pending
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", irqN, 1'b1);
    rst_n = 1'b1;
    doWrite(16'hE001, 8'h00);
    doLine(4);             // latch reset to 0 -> zero after tick
    check("R1 latch cleared", irqN, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: expired expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule